// File: doc/BRIEF.md
# PWM Bus Symbol Receiver

This block turns a dominant/passive serial bus level into pulse-width-modulated line symbols. After a two-flop synchronizer it times every dominant pulse and every full symbol period against a microsecond tick. From the pair of measurements it decides whether the symbol is a start-of-frame, a data 0, a data 1 or a break. Each decision is checked against its own tolerance window for pulse width, for period and, for a data 0, for passive time. A symbol that fits no window raises a symbol error and throws away the frame in progress.

Data bits count only inside a frame opened by a start-of-frame. They are shifted in most significant bit first, and a byte strobe fires on every eighth bit. The block also watches how long the bus stays passive after the last data bit began. At 43 µs it marks end-of-data and reports a partial byte as a framing error. At 69 µs it marks end-of-frame, and at 86 µs it marks inter-frame separation.

The tick is a cycle prescaler (`TICK_DIV` clocks per µs) that restarts at every dominant rising edge. Every measurement is therefore the whole number of microseconds since the current symbol began, floor(cycles / `TICK_DIV`).

Top module: `pwm_symbol_rx`

## Requirements
- R1: While `rst` is high and in the cycles after it falls, every strobe output is low and `byte_data` is 0. A reset in the middle of a frame closes that frame, so data bits that follow without a new start-of-frame are not reported.
- R2: A dominant pulse (`bus_in` = 1) is classified by its width. 5–12 µs is a data 1 (`sym_kind` = 2). 13–20 µs is a data 0 (`sym_kind` = 1). 29–36 µs is a start-of-frame (`sym_kind` = 0). 37–44 µs is a break (`sym_kind` = 3). Any other width pulses `sym_err`.
- R3: A data symbol is accepted only if the next dominant edge arrives 21–28 µs after its start. A data 0 must also have 4–15 µs of passive time. Otherwise `sym_err` pulses in place of the symbol.
- R4: A start-of-frame or break is accepted only if the next dominant edge arrives 45–52 µs after its start. A break followed by passive bus for more than 52 µs is still reported as a break. A start-of-frame followed by passive bus for more than 52 µs pulses `sym_err`.
- R5: Data symbols are reported on `sym_valid` only while a frame is open. A start-of-frame opens a frame. End-of-data, a break, a symbol error or a reset closes it. Data symbols outside a frame produce no output at all.
- R6: Data bits are shifted into a byte with the most significant bit first. On every eighth bit of a frame, `byte_valid` pulses with the byte on `byte_data`, in the same cycle as that bit's `sym_valid`.
- R7: If no dominant edge follows within 43 µs of the start of an in-frame data bit, that bit is reported with `eod` high in the same cycle. A dominant edge that arrives at 29–43 µs is a period error instead.
- R8: If the bit count since the last byte boundary is not zero at end-of-data, `frame_err` pulses together with `eod`, and the partial byte is dropped.
- R9: After an end-of-data, `eof` pulses when 69 µs have passed since the last bit began and `ifs` pulses at 86 µs. A dominant edge before either point cancels whatever has not yet been reported.
- R10: A symbol error drops the partial byte and closes the frame. No byte or end-of-data is reported until a new start-of-frame.
- R11: A start-of-frame that arrives inside an open frame restarts byte assembly from bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Bus level, 1 = dominant, asynchronous |
| sym_valid | output | 1 | One-cycle strobe: a symbol was accepted |
| sym_kind | output | 2 | Symbol code: 0 start-of-frame, 1 data 0, 2 data 1, 3 break |
| sym_err | output | 1 | One-cycle strobe: width or period outside every window |
| byte_valid | output | 1 | One-cycle strobe: a byte has been assembled |
| byte_data | output | BYTE_W | Last assembled byte, most significant bit received first |
| eod | output | 1 | One-cycle strobe: end-of-data, together with the last bit |
| frame_err | output | 1 | One-cycle strobe with eod: partial byte at end-of-data |
| eof | output | 1 | One-cycle strobe: end-of-frame time reached |
| ifs | output | 1 | One-cycle strobe: inter-frame separation time reached |

## Verification
The bench builds the block with `TICK_DIV` = 4 and the default 8-bit timer and byte width. Each microsecond is then four clocks, so every window edge (4/5, 12/13, 20/21, 28/29, 36/37, 44/45, 52/53 µs) can be hit exactly with whole-microsecond stimulus. A frame followed by the full 86 µs separation also finishes in a few hundred cycles, which lets one table sweep width and period boundaries for all four symbol kinds. Directed frames then cover end-of-data timing on both sides of 43 µs, cancellation of the separation mark, partial bytes, error recovery, start-of-frame restart and reset in mid-frame.

// File: rtl/pwm_rx_pkg.sv
package pwm_rx_pkg;

    // Symbol codes as seen at the sym_kind port
    typedef enum logic [1:0] {
        SK_SOF  = 2'd0,
        SK_ZERO = 2'd1,
        SK_ONE  = 2'd2,
        SK_BRK  = 2'd3
    } sym_kind_e;

    // Dominant pulse already classified, waiting for its period to close
    typedef enum logic [2:0] {
        PD_NONE,
        PD_ZERO,
        PD_ONE,
        PD_SOF,
        PD_BRK
    } pend_e;

    // Passive-time tracker after end-of-data
    typedef enum logic [1:0] {
        PS_IDLE,
        PS_WAIT_EOF,
        PS_WAIT_IFS
    } post_e;

    // Event passed from the classifier to the frame assembler
    typedef struct packed {
        logic      sym;
        sym_kind_e kind;
        logic      eod;
        logic      err;
        logic      eof;
        logic      ifs;
    } rx_evt_t;

    // Window limits in microseconds
    localparam int W_ONE_LO   = 5;
    localparam int W_ONE_HI   = 12;
    localparam int W_ZERO_LO  = 13;
    localparam int W_ZERO_HI  = 20;
    localparam int W_SOF_LO   = 29;
    localparam int W_SOF_HI   = 36;
    localparam int W_BRK_LO   = 37;
    localparam int W_BRK_HI   = 44;
    localparam int P_BIT_LO   = 21;
    localparam int P_BIT_HI   = 28;
    localparam int P_LONG_LO  = 45;
    localparam int P_LONG_HI  = 52;
    localparam int PAS_LO     = 4;
    localparam int PAS_HI     = 15;
    localparam int T_EOD      = 43;
    localparam int T_EOF      = 69;
    localparam int T_IFS      = 86;

    function automatic logic in_win(int v, int lo, int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic sym_kind_e kind_of(pend_e p);
        case (p)
            PD_ZERO: return SK_ZERO;
            PD_ONE:  return SK_ONE;
            PD_SOF:  return SK_SOF;
            default: return SK_BRK;
        endcase
    endfunction

    function automatic logic is_data(pend_e p);
        return (p == PD_ZERO) || (p == PD_ONE);
    endfunction

endpackage

// File: rtl/pwm_rx_sync.sv
module pwm_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_in,
    output logic rise,
    output logic fall
);
    // sh[0] is the first flop; sh[STAGES-1] is the synchronized level,
    // sh[STAGES] its previous value for edge detection.
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], bus_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/pwm_rx_timer.sv
module pwm_rx_timer #(
    parameter int TICK_DIV = 16,
    parameter int US_W     = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    output logic [US_W-1:0] us
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);
    localparam logic [US_W-1:0]  US_TOP  = '1;

    logic [PRE_W-1:0] pre;

    // On restart the cycle of the edge itself already counts as elapsed,
    // so the prescaler starts at 1: us = floor(elapsed cycles / TICK_DIV).
    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
            us  <= '0;
        end else if (restart) begin
            pre <= PRE_W'(1);
            us  <= '0;
        end else if (us != US_TOP) begin
            if (pre == PRE_TOP) begin
                pre <= '0;
                us  <= us + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_rx_classifier.sv
module pwm_rx_classifier
    import pwm_rx_pkg::*;
#(
    parameter int US_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rise,
    input  logic            fall,
    input  logic [US_W-1:0] us,
    output rx_evt_t         evt
);
    logic            in_dom, in_dom_n;
    pend_e           pend, pend_n;
    logic [US_W-1:0] pend_w, pend_w_n;
    post_e           post, post_n;
    rx_evt_t         evt_n;
    logic            ok;
    int              us_i, pas_i;

    always_comb begin
        in_dom_n = in_dom;
        pend_n   = pend;
        pend_w_n = pend_w;
        post_n   = post;
        evt_n    = '0;
        evt_n.kind = SK_SOF;
        us_i     = int'(us);
        pas_i    = int'(us) - int'(pend_w);
        ok       = 1'b0;

        if (rise) begin
            // Close the period of the pending symbol
            if (pend != PD_NONE) begin
                if (is_data(pend))
                    ok = in_win(us_i, P_BIT_LO, P_BIT_HI) &&
                         ((pend != PD_ZERO) || in_win(pas_i, PAS_LO, PAS_HI));
                else
                    ok = in_win(us_i, P_LONG_LO, P_LONG_HI);
                if (ok) begin
                    evt_n.sym  = 1'b1;
                    evt_n.kind = kind_of(pend);
                end else begin
                    evt_n.err  = 1'b1;
                end
            end
            in_dom_n = 1'b1;
            pend_n   = PD_NONE;
            post_n   = PS_IDLE;
        end else if (fall && in_dom) begin
            // Classify the dominant width
            in_dom_n = 1'b0;
            pend_w_n = us;
            if (in_win(us_i, W_ONE_LO, W_ONE_HI))        pend_n = PD_ONE;
            else if (in_win(us_i, W_ZERO_LO, W_ZERO_HI)) pend_n = PD_ZERO;
            else if (in_win(us_i, W_SOF_LO, W_SOF_HI))   pend_n = PD_SOF;
            else if (in_win(us_i, W_BRK_LO, W_BRK_HI))   pend_n = PD_BRK;
            else begin
                pend_n    = PD_NONE;
                evt_n.err = 1'b1;
            end
        end else if (!in_dom) begin
            // Passive-time marks
            if (is_data(pend) && us == US_W'(T_EOD)) begin
                evt_n.sym  = 1'b1;
                evt_n.kind = kind_of(pend);
                evt_n.eod  = 1'b1;
                pend_n     = PD_NONE;
                post_n     = PS_WAIT_EOF;
            end else if (pend == PD_SOF && us == US_W'(P_LONG_HI + 1)) begin
                evt_n.err  = 1'b1;
                pend_n     = PD_NONE;
            end else if (pend == PD_BRK && us == US_W'(P_LONG_HI + 1)) begin
                evt_n.sym  = 1'b1;
                evt_n.kind = SK_BRK;
                pend_n     = PD_NONE;
            end else if (post == PS_WAIT_EOF && us == US_W'(T_EOF)) begin
                evt_n.eof  = 1'b1;
                post_n     = PS_WAIT_IFS;
            end else if (post == PS_WAIT_IFS && us == US_W'(T_IFS)) begin
                evt_n.ifs  = 1'b1;
                post_n     = PS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_dom <= 1'b0;
            pend   <= PD_NONE;
            pend_w <= '0;
            post   <= PS_IDLE;
            evt    <= '0;
        end else begin
            in_dom <= in_dom_n;
            pend   <= pend_n;
            pend_w <= pend_w_n;
            post   <= post_n;
            evt    <= evt_n;
        end
    end
endmodule

// File: rtl/pwm_rx_assembler.sv
module pwm_rx_assembler
    import pwm_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt,
    output logic              sym_valid,
    output logic [1:0]        sym_kind,
    output logic              sym_err,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              eod,
    output logic              frame_err,
    output logic              eof,
    output logic              ifs
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST = BC_W'(BYTE_W - 1);

    logic              in_frame, in_frame_n;
    logic              eod_ok, eod_ok_n;
    logic [BC_W-1:0]   bcnt, bcnt_n;
    logic [BYTE_W-1:0] sh, sh_n;

    logic              sv_n, se_n, bv_n, eod_n, fe_n, eof_n, ifs_n;
    logic [1:0]        kind_n;
    logic [BYTE_W-1:0] bd_n;

    always_comb begin
        in_frame_n = in_frame;
        eod_ok_n   = eod_ok;
        bcnt_n     = bcnt;
        sh_n       = sh;
        sv_n = 1'b0; se_n = 1'b0; bv_n = 1'b0;
        eod_n = 1'b0; fe_n = 1'b0; eof_n = 1'b0; ifs_n = 1'b0;
        kind_n = sym_kind;
        bd_n   = byte_data;

        if (evt.err) begin
            se_n       = 1'b1;
            in_frame_n = 1'b0;
            bcnt_n     = '0;
            eod_ok_n   = 1'b0;
        end else if (evt.sym) begin
            eod_ok_n = 1'b0;
            case (evt.kind)
                SK_SOF: begin
                    sv_n       = 1'b1;
                    kind_n     = evt.kind;
                    in_frame_n = 1'b1;
                    bcnt_n     = '0;
                end
                SK_BRK: begin
                    sv_n       = 1'b1;
                    kind_n     = evt.kind;
                    in_frame_n = 1'b0;
                    bcnt_n     = '0;
                end
                default: begin
                    if (in_frame) begin
                        sv_n   = 1'b1;
                        kind_n = evt.kind;
                        sh_n   = {sh[BYTE_W-2:0], (evt.kind == SK_ONE)};
                        if (bcnt == LAST) begin
                            bv_n   = 1'b1;
                            bd_n   = sh_n;
                            bcnt_n = '0;
                        end else begin
                            bcnt_n = bcnt + 1'b1;
                        end
                        if (evt.eod) begin
                            eod_n      = 1'b1;
                            fe_n       = (bcnt != LAST);
                            in_frame_n = 1'b0;
                            bcnt_n     = '0;
                            eod_ok_n   = 1'b1;
                        end
                    end
                end
            endcase
        end else if (evt.eof && eod_ok) begin
            eof_n = 1'b1;
        end else if (evt.ifs && eod_ok) begin
            ifs_n    = 1'b1;
            eod_ok_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame   <= 1'b0;
            eod_ok     <= 1'b0;
            bcnt       <= '0;
            sh         <= '0;
            sym_valid  <= 1'b0;
            sym_kind   <= '0;
            sym_err    <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            eod        <= 1'b0;
            frame_err  <= 1'b0;
            eof        <= 1'b0;
            ifs        <= 1'b0;
        end else begin
            in_frame   <= in_frame_n;
            eod_ok     <= eod_ok_n;
            bcnt       <= bcnt_n;
            sh         <= sh_n;
            sym_valid  <= sv_n;
            sym_kind   <= kind_n;
            sym_err    <= se_n;
            byte_valid <= bv_n;
            byte_data  <= bd_n;
            eod        <= eod_n;
            frame_err  <= fe_n;
            eof        <= eof_n;
            ifs        <= ifs_n;
        end
    end
endmodule

// File: rtl/pwm_symbol_rx.sv
module pwm_symbol_rx
    import pwm_rx_pkg::*;
#(
    parameter int TICK_DIV    = 16,
    parameter int US_W        = 8,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_in,
    output logic              sym_valid,
    output logic [1:0]        sym_kind,
    output logic              sym_err,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              eod,
    output logic              frame_err,
    output logic              eof,
    output logic              ifs
);
    logic            rise, fall;
    logic [US_W-1:0] us;
    rx_evt_t         evt;

    pwm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .bus_in (bus_in),
        .rise   (rise),
        .fall   (fall)
    );

    pwm_rx_timer #(.TICK_DIV(TICK_DIV), .US_W(US_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (rise),
        .us      (us)
    );

    pwm_rx_classifier #(.US_W(US_W)) u_cls (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .fall (fall),
        .us   (us),
        .evt  (evt)
    );

    pwm_rx_assembler #(.BYTE_W(BYTE_W)) u_asm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .sym_valid  (sym_valid),
        .sym_kind   (sym_kind),
        .sym_err    (sym_err),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .eod        (eod),
        .frame_err  (frame_err),
        .eof        (eof),
        .ifs        (ifs)
    );
endmodule

// File: rtl/pwm_symbol_rx_chk.sv
module pwm_symbol_rx_chk
    import pwm_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sym_valid,
    input logic [1:0] sym_kind,
    input logic       sym_err,
    input logic       byte_valid,
    input logic       eod,
    input logic       frame_err,
    input logic       eof,
    input logic       ifs
);
    logic framed, saw_eof, data_sym;

    assign data_sym = sym_valid && (sym_kind == SK_ZERO || sym_kind == SK_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            framed  <= 1'b0;
            saw_eof <= 1'b0;
        end else begin
            if (sym_err || eod || (sym_valid && sym_kind == SK_BRK)) framed <= 1'b0;
            else if (sym_valid && sym_kind == SK_SOF)                framed <= 1'b1;
            if (sym_valid || sym_err || ifs) saw_eof <= 1'b0;
            else if (eof)                    saw_eof <= 1'b1;
        end
    end

    // R2
    sym_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sym_valid && sym_err));

    // R5
    data_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        data_sym |-> framed);

    // R6
    byte_on_data_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> data_sym);

    // R7
    eod_with_bit_chk: assert property (@(posedge clk) disable iff (rst)
        eod |-> data_sym);

    // R8
    ferr_with_eod_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> eod);

    // R9
    ifs_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
        ifs |-> saw_eof);

    // R10
    err_closes_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sym_err |=> !byte_valid && !eod);
endmodule

bind pwm_symbol_rx pwm_symbol_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sym_valid  (sym_valid),
    .sym_kind   (sym_kind),
    .sym_err    (sym_err),
    .byte_valid (byte_valid),
    .eod        (eod),
    .frame_err  (frame_err),
    .eof        (eof),
    .ifs        (ifs)
);

// File: tb/pwm_symbol_rx_test.sv
module pwm_symbol_rx_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_in = 1'b0;
    logic       sym_valid, sym_err, byte_valid, eod, frame_err, eof, ifs;
    logic [1:0] sym_kind;
    logic [7:0] byte_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int n_sym, n_err, n_byte, n_eod, n_ferr, n_eof, n_ifs;
    int kinds [0:63];
    int bytes [0:15];

    always #4 clk = ~clk;

    pwm_symbol_rx #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .bus_in(bus_in),
        .sym_valid(sym_valid), .sym_kind(sym_kind), .sym_err(sym_err),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .eod(eod), .frame_err(frame_err), .eof(eof), .ifs(ifs)
    );

    // Event log, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (sym_valid) begin
                if (n_sym < 64) kinds[n_sym] = int'(sym_kind);
                n_sym++;
            end
            if (byte_valid) begin
                if (n_byte < 16) bytes[n_byte] = int'(byte_data);
                n_byte++;
            end
            if (sym_err)   n_err++;
            if (eod)       n_eod++;
            if (frame_err) n_ferr++;
            if (eof)       n_eof++;
            if (ifs)       n_ifs++;
        end
    end

    task automatic clear_log();
        n_sym = 0; n_err = 0; n_byte = 0; n_eod = 0;
        n_ferr = 0; n_eof = 0; n_ifs = 0;
        for (int k = 0; k < 64; k++) kinds[k] = -1;
        for (int k = 0; k < 16; k++) bytes[k] = -1;
    endtask

    task automatic chk(input int got, input int exp, input string tag);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic sym(input int d, input int p);
        bus_in = 1'b1;
        wait_us(d);
        bus_in = 1'b0;
        wait_us(p - d);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int k = 7; k > 7 - nbits; k--) begin
            if (b[k]) sym(7, 24);
            else      sym(15, 24);
        end
    endtask

    // dom us, period us, expect error, expected kind, requirement
    localparam int NV = 26;
    localparam int VEC [0:NV-1][0:4] = '{
        '{ 7, 24, 0,  2, 2},   // R2 nominal one
        '{ 5, 24, 0,  2, 2},   // R2 one lower edge
        '{12, 24, 0,  2, 2},   // R2 one upper edge
        '{ 4, 24, 1, -1, 2},   // R2 below one
        '{15, 24, 0,  1, 2},   // R2 nominal zero
        '{13, 24, 0,  1, 2},   // R2 zero lower edge
        '{20, 24, 0,  1, 2},   // R2 zero upper edge
        '{21, 28, 1, -1, 2},   // R2 gap between zero and start
        '{28, 48, 1, -1, 2},   // R2 just below start
        '{45, 52, 1, -1, 2},   // R2 above break
        '{16, 21, 0,  1, 3},   // R3 shortest data period
        '{13, 28, 0,  1, 3},   // R3 longest period, passive 15
        '{16, 29, 1, -1, 3},   // R3 period too long
        '{16, 20, 1, -1, 3},   // R3 period too short
        '{ 9, 20, 1, -1, 3},   // R3 one with short period
        '{12, 28, 0,  2, 3},   // R3 one at longest period
        '{20, 23, 1, -1, 3},   // R3 zero with passive 3
        '{10, 25, 0,  2, 3},   // R3 one mid window
        '{39, 48, 0,  3, 4},   // R4 nominal break
        '{37, 45, 0,  3, 4},   // R4 break lower edges
        '{44, 52, 0,  3, 4},   // R4 break upper edges
        '{39, 44, 1, -1, 4},   // R4 break period short
        '{40, 53, 1, -1, 4},   // R4 break period long
        '{36, 53, 1, -1, 4},   // R4 start period long
        '{31, 48, 0,  0, 11},  // R11 start inside frame
        '{29, 45, 0,  0, 11}   // R11 start lower edges
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_log();
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(int'({sym_valid, sym_err, byte_valid, eod, frame_err, eof, ifs}), 0, "R1 strobes in reset");
        chk(int'(byte_data), 0, "R1 byte_data in reset");
        rst = 1'b0;
        wait_us(100);
        chk(n_sym + n_err + n_eod + n_eof + n_ifs, 0, "R1 quiet after reset");

        // Table of single-symbol cases framed by a start and a trailing one
        for (int i = 0; i < NV; i++) begin
            clear_log();
            sym(31, 48);
            sym(VEC[i][0], VEC[i][1]);
            sym(7, 24);
            wait_us(100);
            if (VEC[i][2] != 0) begin
                chk(n_err, 1, $sformatf("R%0d row %0d error count", VEC[i][4], i));
                chk(n_sym, 1, $sformatf("R%0d row %0d symbols", VEC[i][4], i));
                chk(n_eod, 0, $sformatf("R%0d row %0d eod", VEC[i][4], i));
            end else begin
                chk(n_err, 0, $sformatf("R%0d row %0d error count", VEC[i][4], i));
                chk(kinds[1], VEC[i][3], $sformatf("R%0d row %0d kind", VEC[i][4], i));
                chk(n_sym, (VEC[i][3] == 3) ? 2 : 3, $sformatf("R%0d row %0d symbols", VEC[i][4], i));
                chk(n_eod, (VEC[i][3] == 3) ? 0 : 1, $sformatf("R%0d row %0d eod", VEC[i][4], i));
            end
        end

        // R6 R7 R9: two bytes, then full passive time
        clear_log();
        sym(31, 48); send_bits(8'hA5, 8); send_bits(8'h3C, 8); wait_us(100);
        chk(n_byte, 2, "R6 byte count");
        chk(bytes[0], 8'hA5, "R6 first byte msb first");
        chk(bytes[1], 8'h3C, "R6 second byte");
        chk(n_sym, 17, "R6 symbol count");
        chk(n_eod, 1, "R7 eod");
        chk(n_ferr, 0, "R8 no frame error on whole bytes");
        chk(n_eof, 1, "R9 eof");
        chk(n_ifs, 1, "R9 ifs");

        // R7: last bit period 44 gives eod; trailing bit outside frame (R5)
        clear_log();
        sym(31, 48); send_bits(8'h80, 7); sym(7, 44); sym(7, 24); wait_us(100);
        chk(n_eod, 1, "R7 eod at 44");
        chk(n_byte, 1, "R7 byte before eod");
        chk(bytes[0], 8'h81, "R7 byte value");
        chk(n_sym, 9, "R5 bit after eod dropped");
        chk(n_err, 0, "R7 no error at 44");

        // R7: period 42 is a period error, not end-of-data
        clear_log();
        sym(31, 48); sym(7, 42); sym(7, 24); wait_us(100);
        chk(n_err, 1, "R7 period 42 error");
        chk(n_eod, 0, "R7 period 42 no eod");

        // R9: new edge at 75 us cancels the separation mark
        clear_log();
        sym(31, 48); send_bits(8'h55, 7); sym(7, 75); sym(7, 24); wait_us(100);
        chk(n_eod, 1, "R9 eod before cancel");
        chk(n_eof, 1, "R9 eof before cancel");
        chk(n_ifs, 0, "R9 ifs cancelled");

        // R8: partial byte
        clear_log();
        sym(31, 48); send_bits(8'hF0, 5); wait_us(100);
        chk(n_eod, 1, "R8 eod");
        chk(n_ferr, 1, "R8 frame error");
        chk(n_byte, 0, "R8 no byte");

        // R10: error drops the frame, later bits ignored
        clear_log();
        sym(31, 48); send_bits(8'hE0, 3); sym(25, 48); send_bits(8'h5A, 8); wait_us(100);
        chk(n_err, 1, "R10 error");
        chk(n_byte, 0, "R10 no byte after error");
        chk(n_eod, 0, "R10 no eod after error");

        // R11: start inside frame restarts assembly
        clear_log();
        sym(31, 48); send_bits(8'hE0, 3); sym(31, 48); send_bits(8'h81, 8); wait_us(100);
        chk(n_byte, 1, "R11 one byte");
        chk(bytes[0], 8'h81, "R11 byte value");
        chk(n_ferr, 0, "R11 no frame error");

        // R4: break then idle is a break; start then idle is an error
        clear_log();
        sym(31, 48); sym(39, 48); wait_us(100);
        chk(kinds[1], 3, "R4 break before idle");
        chk(n_err, 0, "R4 break idle no error");
        clear_log();
        sym(31, 48); wait_us(100);
        chk(n_err, 1, "R4 start then idle error");
        chk(n_sym, 0, "R4 start then idle no symbol");

        // R5: data with no start
        clear_log();
        send_bits(8'hC3, 8); wait_us(100);
        chk(n_sym + n_byte + n_eod, 0, "R5 data without start");

        // R1: reset in mid-frame closes it
        clear_log();
        sym(31, 48); send_bits(8'hAA, 4);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(int'({sym_valid, byte_valid, eod}), 0, "R1 mid-frame reset strobes");
        rst = 1'b0;
        clear_log();
        wait_us(60);
        send_bits(8'hAA, 8); wait_us(100);
        chk(n_byte + n_sym, 0, "R1 frame closed by reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule